// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit samples a bank of 28 general-purpose input pins and turns chosen transitions into sticky pending flags. Each pin has its own enable for rising transitions and its own enable for falling transitions. Setting both enables flags a transition in either direction. Software reads the pending flags through a small synchronous register port and clears them by writing ones to the matching bit positions.

The pending flags drive a split set of interrupt lines toward a central interrupt controller. Pins 0 to 10 each own a dedicated line. Pins 11 to 27 share one line that is the OR of their flags. A per-pin wake mask selects which pending flags also raise a single wake request.

Top module: `gpio_edge_irq`

## Requirements
- R1: With the rising enable of a pin set, a 0-to-1 change on that pin sets its pending flag; the flag is readable and drives the outputs after the third rising clock edge following the change.
- R2: With the falling enable of a pin set, a 1-to-0 change on that pin sets its pending flag; a change in the direction that is not enabled sets nothing.
- R3: With both enables of a pin set, a change in either direction sets its pending flag.
- R4: A pending flag stays set until software writes a 1 to its bit of the pending register (offset 0x08); writing 0 to a bit leaves it unchanged.
- R5: Writing all ones to the pending register clears every pending flag at once.
- R6: When a new enabled transition and a clearing write to the same bit fall on the same clock edge, the flag ends up set.
- R7: Output `irq_line[i]` for i in 0 to 10 equals pending flag i.
- R8: Output `irq_shared` is high exactly when at least one pending flag among pins 11 to 27 is set.
- R9: Output `wake_req` is high exactly when some pin has both its pending flag and its wake-mask bit (offset 0x0C) set.
- R10: After reset the rising enable (0x00), falling enable (0x04), pending and wake-mask registers read zero, all outputs are low, and pin changes set no flag.
- R11: The level register (offset 0x10) returns the synchronised pin levels two clock edges after a pin change, and writes to it have no effect.
- R12: Register bits 28 to 31 read as zero at every offset, and each writable register returns the value last written to its 28 pin bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 28 | Asynchronous pin levels |
| req_wr | input | 1 | Write strobe, captured at the rising clock edge |
| req_addr | input | 5 | Byte offset of the register accessed |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `req_addr`, combinational |
| irq_line | output | 11 | Dedicated interrupt lines for pins 0 to 10 |
| irq_shared | output | 1 | Shared interrupt line for pins 11 to 27 |
| wake_req | output | 1 | Wake request |

## Verification
The hardest situation to reach is a transition arriving at the pending register on exactly the edge that a clearing write lands, because the transition must be launched three edges earlier so it crosses the synchroniser in step with the write. The bench counts edges from a pin change made at a falling clock edge and raises the clearing write so it is captured on the third rising edge, while the same write clears another pin that saw no transition. Random rounds then reprogram the enables and wake mask, toggle random pin subsets and mix partial clears, comparing every register and output against a bench model.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   // Register offsets of the access port
   typedef enum logic [4:0] {
      OFS_RISE  = 5'h00,
      OFS_FALL  = 5'h04,
      OFS_PEND  = 5'h08,
      OFS_WAKE  = 5'h0C,
      OFS_LEVEL = 5'h10
   } gpio_ofs_e;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int WIDTH  = 28,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_edge_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[s] <= '0;
         else if (s == 0)
            stage_q[s] <= async_in;
         else
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
   parameter int WIDTH = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   output logic [WIDTH-1:0] hit
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= '0;
      else
         prev_q <= level;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic up, down;
      assign up     =  level[i] & ~prev_q[i];
      assign down   = ~level[i] &  prev_q[i];
      assign hit[i] = (up & rise_en[i]) | (down & fall_en[i]);
   end

endmodule

// File: rtl/gpio_edge_irqmap.sv
module gpio_edge_irqmap #(
   parameter int WIDTH     = 28,
   parameter int DEDICATED = 11
) (
   input  logic [WIDTH-1:0]     pending,
   input  logic [WIDTH-1:0]     wake_mask,
   output logic [DEDICATED-1:0] irq_line,
   output logic                 irq_shared,
   output logic                 wake_req
);

   localparam int SHARED_N = WIDTH - DEDICATED;

   if (DEDICATED < 1 || DEDICATED >= WIDTH) begin : g_bad_split
      $error("gpio_edge_irqmap: DEDICATED must be in 1..WIDTH-1");
   end

   for (genvar i = 0; i < DEDICATED; i++) begin : g_line
      assign irq_line[i] = pending[i];
   end

   logic [SHARED_N-1:0] upper;
   assign upper      = pending[WIDTH-1:DEDICATED];
   assign irq_shared = |upper;
   assign wake_req   = |(pending & wake_mask);

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
   import gpio_edge_pkg::*;
#(
   parameter int NUM_PINS    = 28,
   parameter int DEDICATED   = 11,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PINS-1:0]  pins_in,
   input  logic                 req_wr,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic [DATA_W-1:0]    rd_data,
   output logic [DEDICATED-1:0] irq_line,
   output logic                 irq_shared,
   output logic                 wake_req
);

   localparam int PAD_W = DATA_W - NUM_PINS;

   if (NUM_PINS >= DATA_W) begin : g_bad_width
      $error("gpio_edge_irq: NUM_PINS must be below DATA_W");
   end
   if (ADDR_W != 5) begin : g_bad_addr
      $error("gpio_edge_irq: ADDR_W must be 5");
   end

   logic [NUM_PINS-1:0] level_s;
   logic [NUM_PINS-1:0] hit_vec;
   logic [NUM_PINS-1:0] rise_en_q, fall_en_q, wake_q, status_q;
   logic [NUM_PINS-1:0] wbits;

   assign wbits = req_wdata[NUM_PINS-1:0];

   gpio_edge_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(pins_in), .sync_out(level_s)
   );

   gpio_edge_detect #(.WIDTH(NUM_PINS)) det_i (
      .clk(clk), .rst_n(rst_n), .level(level_s),
      .rise_en(rise_en_q), .fall_en(fall_en_q), .hit(hit_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en_q <= '0;
         fall_en_q <= '0;
         wake_q    <= '0;
      end else if (req_wr) begin
         if (req_addr == OFS_RISE) rise_en_q <= wbits;
         if (req_addr == OFS_FALL) fall_en_q <= wbits;
         if (req_addr == OFS_WAKE) wake_q    <= wbits;
      end
   end

   // Write-one-to-clear; a fresh hit on the same edge takes precedence
   logic [NUM_PINS-1:0] clr_vec;
   assign clr_vec = (req_wr && req_addr == OFS_PEND) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= '0;
      else
         status_q <= (status_q & ~clr_vec) | hit_vec;
   end

   always_comb begin
      logic [NUM_PINS-1:0] sel;
      case (req_addr)
         OFS_RISE:  sel = rise_en_q;
         OFS_FALL:  sel = fall_en_q;
         OFS_PEND:  sel = status_q;
         OFS_WAKE:  sel = wake_q;
         OFS_LEVEL: sel = level_s;
         default:   sel = '0;
      endcase
      rd_data = {{PAD_W{1'b0}}, sel};
   end

   gpio_edge_irqmap #(.WIDTH(NUM_PINS), .DEDICATED(DEDICATED)) map_i (
      .pending(status_q), .wake_mask(wake_q),
      .irq_line(irq_line), .irq_shared(irq_shared), .wake_req(wake_req)
   );

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
   import gpio_edge_pkg::*;
#(
   parameter int NUM_PINS = 28,
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_wr,
   input logic [ADDR_W-1:0]   req_addr,
   input logic [DATA_W-1:0]   req_wdata,
   input logic [NUM_PINS-1:0] status,
   input logic [NUM_PINS-1:0] hit,
   input logic [NUM_PINS-1:0] rise_en,
   input logic [NUM_PINS-1:0] fall_en
);

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_wr && req_addr == OFS_PEND) |=> ((($past(status)) & ~status) == '0));

   // R4
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && req_addr == OFS_PEND) |=>
         ((status & $past(req_wdata[NUM_PINS-1:0] & ~hit)) == '0));

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((status & $past(hit)) == $past(hit)));

   // R1
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));

   // R10
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_en == '0 && fall_en == '0) |-> (hit == '0));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
   .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr),
   .req_wdata(req_wdata), .status(status_q), .hit(hit_vec),
   .rise_en(rise_en_q), .fall_en(fall_en_q)
);

// File: tb/gpio_edge_irq_tb_top.sv
module gpio_edge_irq_tb_top;

   localparam int N = 28;
   localparam int D = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins_in = '0;
   logic          req_wr = 1'b0;
   logic [4:0]    req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic [31:0]   rd_data;
   logic [D-1:0]  irq_line;
   logic          irq_shared;
   logic          wake_req;

   int n_tests = 0;
   int n_fail  = 0;

   logic [N-1:0] m_rise = '0, m_fall = '0, m_wake = '0, m_pend = '0;

   always #5 clk = ~clk;

   gpio_edge_irq dut_i (
      .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
      .irq_line(irq_line), .irq_shared(irq_shared), .wake_req(wake_req)
   );

   function automatic logic [N-1:0] edges(input logic [N-1:0] was, input logic [N-1:0] now,
                                         input logic [N-1:0] r, input logic [N-1:0] f);
      return (now & ~was & r) | (~now & was & f);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      req_wr = 1'b1; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      req_addr = a;
      #1 d = rd_data;
   endtask

   // pin change at a falling edge, then wait until the third rising edge has passed
   task automatic drive_pins(input logic [N-1:0] v);
      @(negedge clk);
      pins_in = v;
      repeat (3) @(posedge clk);
   endtask

   task automatic check_all(input string tag);
      logic [31:0] d;
      rd(5'h08, d);
      check({tag, " R4 pending"}, d, {4'h0, m_pend});
      check({tag, " R7 lines"}, {21'd0, irq_line}, {21'd0, m_pend[D-1:0]});
      check({tag, " R8 shared"}, {31'd0, irq_shared}, {31'd0, |m_pend[N-1:D]});
      check({tag, " R9 wake"}, {31'd0, wake_req}, {31'd0, |(m_pend & m_wake)});
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10 reset state
      rd(5'h00, d); check("R10 rise reset", d, 32'h0);
      rd(5'h04, d); check("R10 fall reset", d, 32'h0);
      rd(5'h0C, d); check("R10 wake reset", d, 32'h0);
      check_all("R10 reset");
      drive_pins('1); drive_pins('0); repeat (2) @(posedge clk);
      check_all("R10 toggles ignored");

      // R11 level register, write ignored
      drive_pins(28'hA5A_5A5A);
      rd(5'h10, d); check("R11 level", d, 32'h0A5A_5A5A);
      wr(5'h10, 32'hFFFF_FFFF);
      rd(5'h10, d); check("R11 level write ignored", d, 32'h0A5A_5A5A);
      drive_pins('0);

      // R12 readback with upper bits zero
      wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, d); check("R12 rise readback", d, 32'h0FFF_FFFF);
      wr(5'h00, 32'h0);

      // R1 rising only on pin 3
      wr(5'h00, 32'h8); m_rise = 28'h8;
      drive_pins(28'h8);
      rd(5'h08, d); check("R1 latency edge 3", d, 32'h8);
      m_pend = 28'h8;
      drive_pins(28'h0); check_all("R1 fall ignored");

      // R2 falling only on pin 20
      wr(5'h00, 32'h0); m_rise = '0;
      wr(5'h04, 32'h0010_0000); m_fall = 28'h010_0000;
      drive_pins(28'h010_0000); check_all("R2 rise ignored");
      drive_pins(28'h0); m_pend |= 28'h010_0000; check_all("R2 fall");

      // R4 write zero no effect, write one clears
      wr(5'h08, 32'h0); check_all("R4 write zero");
      wr(5'h08, 32'h8); m_pend &= ~28'h8; check_all("R4 clear one");

      // R3 both edges on pin 27
      wr(5'h00, 32'h0800_0000); wr(5'h04, 32'h0800_0000);
      m_rise = 28'h800_0000; m_fall = 28'h800_0000;
      drive_pins(28'h800_0000); m_pend |= 28'h800_0000; check_all("R3 rise");
      wr(5'h08, 32'h0800_0000); m_pend &= ~28'h800_0000;
      drive_pins(28'h0); m_pend |= 28'h800_0000; check_all("R3 fall");

      // R5 clear all
      wr(5'h08, 32'hFFFF_FFFF); m_pend = '0; check_all("R5 clear all");

      // R6 edge and clear on the same edge: pin 5 set and cleared together, pin 27 cleared
      wr(5'h00, 32'h20); m_rise = 28'h20;
      wr(5'h04, 32'h0); m_fall = '0;
      drive_pins(28'h800_0000);
      m_pend = '0;
      wr(5'h0C, 32'h0);
      @(negedge clk);
      pins_in = 28'h800_0020;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      req_wr = 1'b1; req_addr = 5'h08; req_wdata = 32'h0800_0020;
      @(posedge clk);
      @(negedge clk) req_wr = 1'b0;
      m_pend = 28'h20;
      check_all("R6 set wins");
      wr(5'h08, 32'hFFFF_FFFF); m_pend = '0;
      drive_pins('0);

      // Random rounds
      for (int it = 0; it < 300; it++) begin
         logic [N-1:0] nv, clr;
         if (it % 10 == 0) begin
            m_rise = N'($urandom); m_fall = N'($urandom); m_wake = N'($urandom);
            wr(5'h00, {4'h0, m_rise}); wr(5'h04, {4'h0, m_fall}); wr(5'h0C, {4'h0, m_wake});
         end
         nv = pins_in ^ (N'($urandom) & N'($urandom));
         m_pend |= edges(pins_in, nv, m_rise, m_fall);
         drive_pins(nv);
         check_all("R1 R2 R3 random");
         if ($urandom_range(0, 2) == 0) begin
            clr = N'($urandom);
            wr(5'h08, {4'h0, clr});
            m_pend &= ~clr;
         end
      end
      check_all("R4 final");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule